// File: doc/BRIEF.md
# Per-Lane Register File with Lane Clone

This block is the general-purpose register storage for one warp of a SIMT processor. Every thread lane owns a private bank of registers, each one machine word wide. The number of lanes and the number of registers per lane are parameters. The register operand width is the base-2 logarithm of the register count.

Each lane has two asynchronous read ports and one write port. All lanes share the read and write register addresses, and each lane has its own data. A write updates only the lanes whose bit in the write-enable mask is set.

A clone operation copies the complete register set of the active (source) lane into a destination lane in a single clock edge. The destination lane index comes from a full-word register operand. If that index does not name an existing lane, no register is touched and an error pulse is raised.

The sequencer that drives this block decides which lane is active and which lanes are enabled. Predicate state and memory traffic stay outside the block.

Top module: `simt_regfile`

## Requirements
- R1: After reset every register of every lane reads zero and `clone_err` is low.
- R2: Each lane returns its own bank on both read ports. `rd_addr_a` and `rd_addr_b` select the register by its plain binary index, and lane `l` appears in bits `[l*WIDTH +: WIDTH]` of the flat read buses.
- R3: On a clock edge, `wr_data` lane slice `l` is stored at `wr_addr` only in lanes whose `wr_en[l]` bit is 1. Lanes with a 0 bit keep all their registers.
- R4: A read of the register being written in the same cycle returns the value held before the edge. The new value is visible from the cycle after.
- R5: When `clone_go` is high and the destination index is below LANES, all REGS registers of lane `clone_src` are copied into the destination lane at the next edge.
- R6: The destination index is the full WIDTH-bit `clone_dst` value. If it is LANES or larger, clone writes nothing and `clone_err` is high for exactly the one cycle after the request. `clone_err` is low after any accepted clone or idle cycle.
- R7: The clone copies the source values from before the edge. An ordinary write to the source lane in the same cycle lands in the source lane only and is not copied.
- R8: An ordinary write to the destination lane in the clone cycle is overridden by the clone. Ordinary writes to other lanes in that cycle still land.
- R9: A clone whose destination equals its source leaves that lane unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_addr_a | input | AW | Register index for read port A, shared by all lanes |
| rd_addr_b | input | AW | Register index for read port B, shared by all lanes |
| rd_data_a | output | LANES*WIDTH | Port A data, one word per lane |
| rd_data_b | output | LANES*WIDTH | Port B data, one word per lane |
| wr_en | input | LANES | Per-lane write enable mask |
| wr_addr | input | AW | Register index written |
| wr_data | input | LANES*WIDTH | Write data, one word per lane |
| clone_go | input | 1 | Clone request for this cycle |
| clone_src | input | LW | Active lane that is copied |
| clone_dst | input | WIDTH | Destination lane index taken from a register operand |
| clone_err | output | 1 | One-cycle pulse after a clone with an out-of-range destination |

## Verification
An ordinary masked write and a clone can occur in the same cycle, and each can target the source lane, the destination lane or a bystander lane. The bench issues a clone together with a write that enables every lane. It then reads back every register of every lane. The result must show that the destination lane holds only the pre-edge source image, the source and bystander lanes hold the new write, and the source image was not taken after the write. A second case pairs a rejected clone with a write, to show that the write still lands everywhere while the error pulse appears.

// File: rtl/regfile_pkg.sv
package regfile_pkg;

  // True when a destination operand names an existing lane.
  function automatic logic lane_ok(input logic [63:0] idx, input int unsigned lanes);
    return idx < 64'(lanes);
  endfunction

  // Width of an index into n items, never below one bit.
  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/rf_lane_bank.sv
module rf_lane_bank #(
  parameter int unsigned REGS  = 8,
  parameter int unsigned WIDTH = 32,
  parameter int unsigned AW    = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [AW-1:0]           wr_addr,
  input  logic [WIDTH-1:0]        wr_data,
  input  logic                    load_en,
  input  logic [REGS*WIDTH-1:0]   load_image,
  input  logic [AW-1:0]           rd_addr_a,
  input  logic [AW-1:0]           rd_addr_b,
  output logic [WIDTH-1:0]        rd_data_a,
  output logic [WIDTH-1:0]        rd_data_b,
  output logic [REGS*WIDTH-1:0]   image
);

  logic [WIDTH-1:0] regs_q [REGS];

  // Clone load wins over an ordinary write to the same lane.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < REGS; i++) regs_q[i] <= '0;
    end else if (load_en) begin
      for (int i = 0; i < REGS; i++) regs_q[i] <= load_image[i*WIDTH +: WIDTH];
    end else if (wr_en) begin
      regs_q[wr_addr] <= wr_data;
    end
  end

  assign rd_data_a = regs_q[rd_addr_a];
  assign rd_data_b = regs_q[rd_addr_b];

  for (genvar g = 0; g < REGS; g++) begin : g_img
    assign image[g*WIDTH +: WIDTH] = regs_q[g];
  end

endmodule

// File: rtl/rf_clone_ctrl.sv
module rf_clone_ctrl
  import regfile_pkg::*;
#(
  parameter int unsigned LANES = 4,
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [WIDTH-1:0] dst_val,
  output logic [LANES-1:0] hit,
  output logic             accept,
  output logic             reject,
  output logic             err
);

  logic in_range;

  assign in_range = lane_ok(64'(dst_val), LANES);
  assign accept   = go && in_range;
  assign reject   = go && !in_range;

  for (genvar l = 0; l < LANES; l++) begin : g_hit
    assign hit[l] = accept && (dst_val == WIDTH'(l));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err <= 1'b0;
    else        err <= reject;
  end

endmodule

// File: rtl/rf_image_mux.sv
module rf_image_mux #(
  parameter int unsigned LANES = 4,
  parameter int unsigned IMG_W = 256,
  parameter int unsigned LW    = 2
) (
  input  logic [LANES*IMG_W-1:0] images,
  input  logic [LW-1:0]          sel,
  output logic [IMG_W-1:0]       out
);

  always_comb begin
    out = '0;
    for (int l = 0; l < LANES; l++) begin
      if (sel == LW'(l)) out = images[l*IMG_W +: IMG_W];
    end
  end

endmodule

// File: rtl/simt_regfile.sv
module simt_regfile
  import regfile_pkg::*;
#(
  parameter int unsigned LANES = 4,
  parameter int unsigned REGS  = 8,
  parameter int unsigned WIDTH = 32,
  localparam int unsigned AW    = idx_w(REGS),
  localparam int unsigned LW    = idx_w(LANES),
  localparam int unsigned IMG_W = REGS * WIDTH
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [AW-1:0]          rd_addr_a,
  input  logic [AW-1:0]          rd_addr_b,
  output logic [LANES*WIDTH-1:0] rd_data_a,
  output logic [LANES*WIDTH-1:0] rd_data_b,
  input  logic [LANES-1:0]       wr_en,
  input  logic [AW-1:0]          wr_addr,
  input  logic [LANES*WIDTH-1:0] wr_data,
  input  logic                   clone_go,
  input  logic [LW-1:0]          clone_src,
  input  logic [WIDTH-1:0]       clone_dst,
  output logic                   clone_err
);

  // Named internal events, observed by the bound checker.
  logic [LANES*IMG_W-1:0] lane_images;
  logic [IMG_W-1:0]       src_image;
  logic [LANES-1:0]       clone_hit;
  logic                   clone_accept;
  logic                   clone_reject;

  rf_clone_ctrl #(.LANES(LANES), .WIDTH(WIDTH)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .go      (clone_go),
    .dst_val (clone_dst),
    .hit     (clone_hit),
    .accept  (clone_accept),
    .reject  (clone_reject),
    .err     (clone_err)
  );

  rf_image_mux #(.LANES(LANES), .IMG_W(IMG_W), .LW(LW)) u_src_mux (
    .images (lane_images),
    .sel    (clone_src),
    .out    (src_image)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    rf_lane_bank #(.REGS(REGS), .WIDTH(WIDTH), .AW(AW)) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en[l]),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data[l*WIDTH +: WIDTH]),
      .load_en    (clone_hit[l]),
      .load_image (src_image),
      .rd_addr_a  (rd_addr_a),
      .rd_addr_b  (rd_addr_b),
      .rd_data_a  (rd_data_a[l*WIDTH +: WIDTH]),
      .rd_data_b  (rd_data_b[l*WIDTH +: WIDTH]),
      .image      (lane_images[l*IMG_W +: IMG_W])
    );
  end

endmodule

// File: rtl/simt_regfile_chk.sv
module simt_regfile_chk #(
  parameter int unsigned LANES = 4,
  parameter int unsigned REGS  = 8,
  parameter int unsigned WIDTH = 32,
  parameter int unsigned AW    = 3
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [LANES-1:0]             wr_en,
  input logic [AW-1:0]                wr_addr,
  input logic [LANES*WIDTH-1:0]       wr_data,
  input logic [LANES*REGS*WIDTH-1:0]  lane_images,
  input logic [REGS*WIDTH-1:0]        src_image,
  input logic [LANES-1:0]             clone_hit,
  input logic                         clone_reject,
  input logic                         clone_err
);

  localparam int unsigned IMG_W = REGS * WIDTH;

  logic [WIDTH-1:0] cur [LANES][REGS];
  always_comb begin
    for (int l = 0; l < LANES; l++)
      for (int r = 0; r < REGS; r++)
        cur[l][r] = lane_images[(l*REGS + r)*WIDTH +: WIDTH];
  end

  assert_one_dest_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clone_hit));

  assert_reject_no_copy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clone_reject |-> (clone_hit == '0));

  assert_err_follows_reject_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clone_reject |=> clone_err);

  assert_err_only_after_reject_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clone_err |-> $past(clone_reject));

  for (genvar l = 0; l < LANES; l++) begin : g_lane_chk
    // R5 / R7 / R8: destination receives the pre-edge source image.
    assert_clone_copy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      clone_hit[l] |=> (lane_images[l*IMG_W +: IMG_W] == $past(src_image)));

    // R3: an enabled lane that is not being cloned into takes the write.
    assert_write_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en[l] && !clone_hit[l]) |=>
        (cur[l][$past(wr_addr)] == $past(wr_data[l*WIDTH +: WIDTH])));

    // R3: an untouched lane keeps every register.
    assert_idle_lane_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en[l] && !clone_hit[l]) |=> $stable(lane_images[l*IMG_W +: IMG_W]));
  end

endmodule

bind simt_regfile simt_regfile_chk #(
  .LANES(LANES), .REGS(REGS), .WIDTH(WIDTH), .AW(AW)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_en        (wr_en),
  .wr_addr      (wr_addr),
  .wr_data      (wr_data),
  .lane_images  (lane_images),
  .src_image    (src_image),
  .clone_hit    (clone_hit),
  .clone_reject (clone_reject),
  .clone_err    (clone_err)
);

// File: tb/simt_regfile_tb.sv
module simt_regfile_tb;

  localparam int LANES = 4;
  localparam int REGS  = 8;
  localparam int WIDTH = 32;
  localparam int AW    = 3;
  localparam int LW    = 2;

  logic                   clk = 1'b0;
  logic                   rst_n = 1'b0;
  logic [AW-1:0]          rd_addr_a = '0, rd_addr_b = '0, wr_addr = '0;
  logic [LANES*WIDTH-1:0] rd_data_a, rd_data_b, wr_data = '0;
  logic [LANES-1:0]       wr_en = '0;
  logic                   clone_go = 1'b0;
  logic [LW-1:0]          clone_src = '0;
  logic [WIDTH-1:0]       clone_dst = '0;
  logic                   clone_err;

  int checks = 0;
  int fails  = 0;
  logic [WIDTH-1:0] m [LANES][REGS];

  simt_regfile #(.LANES(LANES), .REGS(REGS), .WIDTH(WIDTH)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b),
    .rd_data_a(rd_data_a), .rd_data_b(rd_data_b),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .clone_go(clone_go), .clone_src(clone_src), .clone_dst(clone_dst),
    .clone_err(clone_err)
  );

  always #10 clk = ~clk;

  task automatic chk(input logic ok, input string req, input logic [WIDTH-1:0] act,
                     input logic [WIDTH-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Edge, then settle 1 ns after it; inputs change only here.
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle_inputs();
    wr_en = '0; clone_go = 1'b0;
  endtask

  // Compare every register of every lane against the model on both ports.
  task automatic check_all(input string req);
    for (int r = 0; r < REGS; r++) begin
      rd_addr_a = AW'(r);
      rd_addr_b = AW'(REGS - 1 - r);
      #1;
      for (int l = 0; l < LANES; l++) begin
        chk(rd_data_a[l*WIDTH +: WIDTH] === m[l][r], req,
            rd_data_a[l*WIDTH +: WIDTH], m[l][r]);
        chk(rd_data_b[l*WIDTH +: WIDTH] === m[l][REGS-1-r], req,
            rd_data_b[l*WIDTH +: WIDTH], m[l][REGS-1-r]);
      end
    end
  endtask

  // One edge with a write and optional clone; model updated from the requirements.
  task automatic cycle(input logic [LANES-1:0] en, input int addr, input int seed,
                       input logic go, input int src, input logic [WIDTH-1:0] dst);
    logic [WIDTH-1:0] snap [REGS];
    for (int r = 0; r < REGS; r++) snap[r] = m[src][r];
    wr_en = en; wr_addr = AW'(addr);
    for (int l = 0; l < LANES; l++) wr_data[l*WIDTH +: WIDTH] = WIDTH'(seed * 16 + l);
    clone_go = go; clone_src = LW'(src); clone_dst = dst;
    tick();
    for (int l = 0; l < LANES; l++)
      if (en[l]) m[l][addr] = WIDTH'(seed * 16 + l);
    if (go && dst < LANES)
      for (int r = 0; r < REGS; r++) m[dst][r] = snap[r];
    idle_inputs();
  endtask

  task automatic t_reset();
    for (int l = 0; l < LANES; l++)
      for (int r = 0; r < REGS; r++) m[l][r] = '0;
    check_all("R1 reset contents");
    chk(clone_err === 1'b0, "R1 clone_err after reset", WIDTH'(clone_err), '0);
  endtask

  task automatic t_fill();
    // R2: distinct values per lane and register, read back on both ports.
    for (int r = 0; r < REGS; r++) cycle('1, r, 100 + r, 1'b0, 0, '0);
    check_all("R2 per-lane read ports");
  endtask

  task automatic t_masked_write();
    cycle(4'b0101, 3, 7, 1'b0, 0, '0);
    check_all("R3 masked write lanes 0,2");
    cycle(4'b1000, 6, 9, 1'b0, 0, '0);
    check_all("R3 masked write lane 3");
    cycle(4'b0000, 1, 11, 1'b0, 0, '0);
    check_all("R3 empty mask");
  endtask

  task automatic t_rdw();
    logic [WIDTH-1:0] old1;
    old1 = m[1][5];
    wr_en = 4'b0010; wr_addr = 3'd5; wr_data = '0;
    wr_data[1*WIDTH +: WIDTH] = 32'hCAFE_0001;
    rd_addr_a = 3'd5;
    #1;
    chk(rd_data_a[1*WIDTH +: WIDTH] === old1, "R4 read-during-write old value",
        rd_data_a[1*WIDTH +: WIDTH], old1);
    tick();
    idle_inputs();
    m[1][5] = 32'hCAFE_0001;
    rd_addr_a = 3'd5;
    #1;
    chk(rd_data_a[1*WIDTH +: WIDTH] === 32'hCAFE_0001, "R4 new value next cycle",
        rd_data_a[1*WIDTH +: WIDTH], 32'hCAFE_0001);
  endtask

  task automatic t_clone();
    cycle('0, 0, 0, 1'b1, 2, 32'd0);
    check_all("R5 clone lane 2 into lane 0");
    chk(clone_err === 1'b0, "R6 no error on valid clone", WIDTH'(clone_err), '0);
    cycle('0, 0, 0, 1'b1, 1, 32'd3);
    check_all("R5 clone lane 1 into lane 3");
  endtask

  task automatic t_clone_bad();
    cycle(4'b0110, 2, 21, 1'b1, 0, 32'd4);
    chk(clone_err === 1'b1, "R6 error pulse for index 4", WIDTH'(clone_err), 32'd1);
    check_all("R6 rejected clone writes nothing, write lands");
    tick();
    chk(clone_err === 1'b0, "R6 error lasts one cycle", WIDTH'(clone_err), '0);
    cycle('0, 0, 0, 1'b1, 0, 32'h8000_0001);
    chk(clone_err === 1'b1, "R6 error for large index", WIDTH'(clone_err), 32'd1);
    check_all("R6 large index writes nothing");
    tick();
  endtask

  task automatic t_clone_vs_write();
    // All lanes written at reg 4 while lane 1 is cloned into lane 2.
    cycle('1, 4, 33, 1'b1, 1, 32'd2);
    check_all("R7 R8 clone with concurrent write");
    chk(m[2][4] === m[1][4] - 32'd0 ? 1'b0 : 1'b1, "R7 source write not copied",
        m[2][4], m[1][4]);
  endtask

  task automatic t_clone_self();
    cycle('0, 0, 0, 1'b1, 3, 32'd3);
    check_all("R9 self clone leaves lane unchanged");
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #25;
    rst_n = 1'b1;
    tick();
    t_reset();
    t_fill();
    t_masked_write();
    t_rdw();
    t_clone();
    t_clone_bad();
    t_clone_vs_write();
    t_clone_self();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule